// File: doc/BRIEF.md
# Boot-Time Serial Mode Loader

The loader fetches a processor's fundamental configuration from a slow serial source as soon as power is declared good. It makes its own serial clock by dividing the master clock by `CLK_DIV` (256 by default) and reads exactly `MODE_BITS` bits (256 by default), one per serial clock period. It then presents them as a parallel mode vector with a done flag. A cheap serial memory or a small piece of glue logic can supply the stream at that low rate. Decoding the bits is left to the blocks that read the vector.

A three-state machine controls the block. `LDR_IDLE` waits for `pwr_good`. The transition IDLE→SHIFT is taken on the first master edge at which `pwr_good` is high, and that same edge captures bit 0. `LDR_SHIFT` captures one bit per serial period. The transition SHIFT→HOLD is taken on the edge that captures the last bit. `LDR_HOLD` raises `done`, freezes the vector and keeps the serial clock running. The transitions SHIFT→IDLE and HOLD→IDLE are taken whenever `pwr_good` is seen low. They clear the bit index and `done` and park the serial clock low. `CLK_DIV` must be even and at least 2, and `MODE_BITS` must be at least 2.

Top module: `boot_mode_loader`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `sclk` is 0, `done` is 0 and every bit of `mode` is 0.
- R2: While `pwr_good` is high, `sclk` has a period of `CLK_DIV` master cycles. It is high for `CLK_DIV/2` cycles and low for `CLK_DIV/2` cycles. It rises on the master edge at which `pwr_good` is first sampled high. While `pwr_good` is low, `sclk` is held at 0.
- R3: `sdi` is sampled only on master edges where `sclk` rises. The value sampled at the edge where `pwr_good` is first seen high is stored in `mode[0]`. The value sampled k serial periods later is stored in `mode[k]`.
- R4: Exactly `MODE_BITS` bits are read. `sdi` has no effect on `mode` at any master edge other than a capture edge.
- R5: `done` goes to 1 on the master edge that captures bit `MODE_BITS-1` and is visible in the following cycle. It stays 1 as long as `pwr_good` stays high.
- R6: After loading ends, `sclk` keeps toggling with the R2 timing, no further bits are captured, and `mode` stays unchanged for as long as `done` is 1.
- R7: When `pwr_good` is sampled low, the next state is idle. `done` and `sclk` are 0 in the following cycle and the bit index is cleared. The next assertion of `pwr_good` restarts loading at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Power declared good; high enables loading and the serial clock |
| sdi | input | 1 | Serial mode data in |
| sclk | output | 1 | Serial clock, master clock divided by `CLK_DIV` |
| mode | output | `MODE_BITS` | Loaded mode vector, bit k is stream bit k |
| done | output | 1 | All mode bits are loaded |

## Verification
Let edge A be the first master edge at which `pwr_good` is high. Bit k is due at edge A + k·`CLK_DIV`, so the bench places the true bit on `sdi` only in the cycle before that edge and drives its complement in every other cycle. `sclk` after edge A + i is expected to equal (i mod `CLK_DIV`) < `CLK_DIV/2`. `done` is expected low up to and including the cycle before edge A + (`MODE_BITS`−1)·`CLK_DIV` and high from the cycle after it. The bench drives inputs and reads outputs on the falling edge, so every one of these expectations lines up with a whole count of rising edges since A. A `pwr_good` drop is expected to clear `done` and `sclk` one edge later.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

    typedef enum logic [1:0] {
        LDR_IDLE  = 2'd0,
        LDR_SHIFT = 2'd1,
        LDR_HOLD  = 2'd2
    } ldr_state_t;

endpackage

// File: rtl/bml_divider.sv
module bml_divider #(
    parameter int CLK_DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic tick_o
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] HALF_C = CW'(CLK_DIV / 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    // The counter is parked on its last value while stopped,
    // so the first running cycle wraps to zero and raises sclk.
    always_comb begin
        if (cnt_q == LAST_C) begin
            cnt_nx = '0;
        end else begin
            cnt_nx = cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST_C);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= LAST_C;
            sclk_o <= 1'b0;
        end else if (!run_i) begin
            cnt_q  <= LAST_C;
            sclk_o <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            sclk_o <= (cnt_nx < HALF_C);
        end
    end

    // R2
    sclk_rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (cnt_q == '0));

    // R2
    sclk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !$past(run_i)) |-> !sclk_o);

endmodule

// File: rtl/bml_ctrl.sv
module bml_ctrl
    import boot_mode_pkg::*;
#(
    parameter int MODE_BITS = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pg_i,
    input  logic                          tick_i,
    output logic                          cap_en_o,
    output logic [$clog2(MODE_BITS)-1:0]  cap_idx_o,
    output logic                          done_o
);
    localparam int IW = $clog2(MODE_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(MODE_BITS - 1);
    localparam logic [IW-1:0] ONE_IDX  = IW'(1);

    ldr_state_t    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    // State and index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LDR_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            LDR_IDLE: begin
                idx_d = '0;
                if (tick_i) begin
                    state_d = LDR_SHIFT;
                    idx_d   = ONE_IDX;
                end
            end
            LDR_SHIFT: begin
                if (!pg_i) begin
                    state_d = LDR_IDLE;
                    idx_d   = '0;
                end else if (tick_i) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = LDR_HOLD;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            LDR_HOLD: begin
                if (!pg_i) begin
                    state_d = LDR_IDLE;
                    idx_d   = '0;
                end
            end
            default: begin
                state_d = LDR_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cap_en_o  = 1'b0;
        cap_idx_o = idx_q;
        done_o    = 1'b0;
        unique case (state_q)
            LDR_IDLE: begin
                cap_en_o  = tick_i;
                cap_idx_o = '0;
            end
            LDR_SHIFT: begin
                cap_en_o = tick_i;
            end
            LDR_HOLD: begin
                done_o = 1'b1;
            end
            default: begin
                cap_en_o = 1'b0;
            end
        endcase
    end

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pg_i) |=> done_o);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(cap_en_o) && ($past(cap_idx_o) == LAST_IDX)));

    // R7
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_i |=> !done_o);

endmodule

// File: rtl/bml_capture.sv
module bml_capture #(
    parameter int MODE_BITS = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap_en_i,
    input  logic [$clog2(MODE_BITS)-1:0]  cap_idx_i,
    input  logic                          sdi_i,
    output logic [MODE_BITS-1:0]          mode_o
);
    logic [MODE_BITS-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cap_en_i) begin
            mode_q[cap_idx_i] <= sdi_i;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader #(
    parameter int CLK_DIV   = 256,
    parameter int MODE_BITS = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_good,
    input  logic                 sdi,
    output logic                 sclk,
    output logic [MODE_BITS-1:0] mode,
    output logic                 done
);
    localparam int IW = $clog2(MODE_BITS);

    logic          tick;
    logic          cap_en;
    logic [IW-1:0] cap_idx;

    bml_divider #(
        .CLK_DIV (CLK_DIV)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (pwr_good),
        .sclk_o (sclk),
        .tick_o (tick)
    );

    bml_ctrl #(
        .MODE_BITS (MODE_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pg_i      (pwr_good),
        .tick_i    (tick),
        .cap_en_o  (cap_en),
        .cap_idx_o (cap_idx),
        .done_o    (done)
    );

    bml_capture #(
        .MODE_BITS (MODE_BITS)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en_i  (cap_en),
        .cap_idx_i (cap_idx),
        .sdi_i     (sdi),
        .mode_o    (mode)
    );

    // R3
    cap_on_sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> $rose(sclk));

    // R6
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pwr_good) |=> $stable(mode));

endmodule

// File: tb/boot_mode_loader_test.sv
module boot_mode_loader_test;

    localparam int DA = 256;
    localparam int BA = 256;
    localparam int DB = 8;
    localparam int BB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg_a = 1'b0, sdi_a = 1'b0, sclk_a, done_a;
    logic pg_b = 1'b0, sdi_b = 1'b0, sclk_b, done_b;
    logic [BA-1:0] mode_a;
    logic [BB-1:0] mode_b;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    boot_mode_loader #(.CLK_DIV(DA), .MODE_BITS(BA)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pg_a), .sdi(sdi_a),
        .sclk(sclk_a), .mode(mode_a), .done(done_a));

    boot_mode_loader #(.CLK_DIV(DB), .MODE_BITS(BB)) uut_s (
        .clk(clk), .rst_n(rst_n), .pwr_good(pg_b), .sdi(sdi_b),
        .sclk(sclk_b), .mode(mode_b), .done(done_b));

    function automatic logic sclk_of(input int sel);
        return (sel == 0) ? sclk_a : sclk_b;
    endfunction

    function automatic logic done_of(input int sel);
        return (sel == 0) ? done_a : done_b;
    endfunction

    function automatic logic [255:0] mode_of(input int sel);
        return (sel == 0) ? mode_a : 256'(mode_b);
    endfunction

    task automatic drive(input int sel, input logic pg, input logic d);
        if (sel == 0) begin
            pg_a = pg; sdi_a = d;
        end else begin
            pg_b = pg; sdi_b = d;
        end
    endtask

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Drop pwr_good and confirm the idle outputs one edge later (R7).
    task automatic drop(input int sel);
        @(negedge clk);
        drive(sel, 1'b0, 1'b0);
        @(negedge clk);
        chk("R7 done cleared after drop", 256'(done_of(sel)), 256'(0));
        chk("R7 sclk parked after drop", 256'(sclk_of(sel)), 256'(0));
    endtask

    // Full load: the true bit is driven only before capture edges, the
    // complement everywhere else; extra cycles run past the end.
    task automatic run_load(input int sel, input int div, input int nbits,
                            input logic [255:0] pat, input int extra);
        logic [255:0] mask;
        mask = (nbits >= 256) ? {256{1'b1}} : ((256'(1) << nbits) - 256'(1));
        for (int j = 0; j < nbits * div + extra; j++) begin
            @(negedge clk);
            if (j == 0) begin
                chk("R2 sclk low before start", 256'(sclk_of(sel)), 256'(0));
            end else if (j > nbits * div) begin
                chk("R6 sclk keeps toggling", 256'(sclk_of(sel)),
                    256'(((j - 1) % div) < (div / 2)));
            end else begin
                chk("R2 sclk phase", 256'(sclk_of(sel)),
                    256'(((j - 1) % div) < (div / 2)));
            end
            chk("R5 done timing", 256'(done_of(sel)), 256'(j > (nbits - 1) * div));
            if (j == (nbits - 1) * div + 1) begin
                chk("R3 mode at done", mode_of(sel), pat & mask);
            end
            if ((j % div == 0) && (j / div < nbits)) begin
                drive(sel, 1'b1, pat[j / div]);
            end else begin
                drive(sel, 1'b1, ~pat[(j / div) % nbits]);
            end
        end
        @(negedge clk);
        chk("R4 R6 mode after extra cycles", mode_of(sel), pat & mask);
        chk("R5 done held", 256'(done_of(sel)), 256'(1));
    endtask

    task automatic partial(input int sel, input int cycles);
        for (int j = 0; j < cycles; j++) begin
            @(negedge clk);
            drive(sel, 1'b1, 1'b1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 during reset
        chk("R1 sclk in reset", 256'(sclk_a), 256'(0));
        chk("R1 done in reset", 256'(done_b), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sclk after reset", {sclk_a, sclk_b}, 256'(0));
        chk("R1 done after reset", {done_a, done_b}, 256'(0));
        chk("R1 mode after reset", mode_a, 256'(0));
        chk("R1 small mode after reset", 256'(mode_b), 256'(0));

        // Sweep of patterns on the small configuration
        run_load(1, DB, BB, 256'h0000, 3 * DB);
        drop(1);
        run_load(1, DB, BB, 256'hFFFF, 3 * DB);
        drop(1);
        run_load(1, DB, BB, 256'hA5C3, 3 * DB);
        drop(1);
        run_load(1, DB, BB, 256'h8001, 2 * DB);
        drop(1);
        run_load(1, DB, BB, 256'h1234, 2 * DB);
        drop(1);
        for (int w = 0; w < BB; w++) begin
            run_load(1, DB, BB, 256'(1) << w, DB);
            drop(1);
        end

        // R7 abort mid-load, then restart must begin at bit 0
        partial(1, 5 * DB + 3);
        drop(1);
        chk("R7 no done after abort", 256'(done_b), 256'(0));
        run_load(1, DB, BB, 256'h0F0F, 2 * DB);
        drop(1);

        // Default configuration, one full load
        run_load(0, DA, BA, {64'hDEADBEEF01234567, 64'h0F1E2D3C4B5A6978,
                             64'h8000000000000001, 64'hC3A5C3A55A3C5A3C}, 2 * DA + 5);
        drop(0);

        report();
        $finish;
    end

endmodule